// File: doc/BRIEF.md
# Locked Translation Lookup with Access Check

This block holds eight pinned address-translation entries and searches all of them at once for a 32-bit virtual address. A separate parallel write port loads the entries. On each lookup the block matches the address against every valid entry. Each entry covers one of four region sizes. Global entries match any address-space identifier, and non-global entries must match the current identifier. An entry also matches only in the security state it was loaded for.

When more than one entry matches, the lowest-numbered matching entry supplies the result. The block builds the physical address and passes on the memory attributes and the memory security attribute. It then checks the access against the entry's permission bits and execute-never flag, and raises either a permission fault or a domain-fault indication.

The search logic is combinational. A single register stage captures the result one cycle after the lookup strobe. Sub-page permissions, domain access control and table walking are handled by other blocks.

Top module: `lktlb_lookup`

## Requirements
- R1: The size field `wr_size_i` selects the region. 2'b00 is 16 MB and compares VA[31:24]. 2'b01 is 4 KB and compares VA[31:12]. 2'b10 is 64 KB and compares VA[31:16]. 2'b11 is 1 MB and compares VA[31:20]. The output address takes the entry's physical bits above the region size and the lookup address bits below it. Physical bits below the region size are ignored.
- R2: An entry loaded with `wr_valid_i`=0 never matches. Rewriting that entry with `wr_valid_i`=1 makes it match.
- R3: An entry loaded with `wr_global_i`=1 matches any `asid_i`. An entry loaded with `wr_global_i`=0 matches only when `asid_i` equals its stored identifier.
- R4: An entry matches only when its stored non-secure flag (`wr_nstid_i`) equals `ns_i`.
- R5: The stored memory-security bit is `wr_nsa_i` OR `wr_nstid_i`. On a hit, `ns_o` shows this stored bit, and `domain_o`, `tex_o`, `c_o`, `b_o` and `s_o` show the entry's fields.
- R6: With the extension bit `wr_apx_i`=0, the 2-bit permission field works as follows. 00 denies every access. 01 allows supervisor read and write only. 10 allows supervisor read and write and user read. 11 allows every read and write. Access codes on `acc_i` are 00 read, 01 write, 10 fetch and 11 read. `priv_i`=1 means supervisor. A fetch needs read permission. A denied access sets `perm_fault_o`.
- R7: With `wr_apx_i`=1, the permission field works as follows. 01 allows supervisor read only. 10 and 11 allow read for both levels, and no writes. 00 sets `dom_fault_o`, clears `perm_fault_o`, and takes priority over every other check. The two fault outputs are never set together.
- R8: A fetch (`acc_i`=2'b10) that hits an entry with execute-never set raises `perm_fault_o`, even when the permission field allows reads.
- R9: When several entries match, the lowest index supplies every result field.
- R10: A lookup with no matching entry gives `miss_o`=1 and `hit_o`=0. It clears both fault outputs, and it sets `pa_o`, `ns_o` and all attribute outputs to zero.
- R11: The results appear at the first clock edge after `lookup_i` is sampled high, and `res_valid_o` is high for exactly that cycle. Without a strobe, `res_valid_o` goes low and all other outputs hold their values.
- R12: A write and a lookup in the same cycle give a lookup result from the entry contents before the write. The write is visible to the next lookup.
- R13: While reset is asserted, and until the first lookup, `res_valid_o`, `hit_o`, `miss_o`, both fault outputs and `pa_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one entry |
| wr_idx_i | input | 3 | Index of the entry to write |
| wr_valid_i | input | 1 | Entry valid |
| wr_vpn_i | input | 20 | Virtual page bits VA[31:12] |
| wr_global_i | input | 1 | Entry ignores the identifier |
| wr_asid_i | input | 8 | Address-space identifier |
| wr_ppn_i | input | 20 | Physical page bits PA[31:12] |
| wr_nsa_i | input | 1 | Memory accesses are non-secure |
| wr_nstid_i | input | 1 | Entry belongs to the non-secure state |
| wr_size_i | input | 2 | Region size code |
| wr_apx_i | input | 1 | Permission extension bit |
| wr_ap_i | input | 2 | Permission field |
| wr_xn_i | input | 1 | Execute-never |
| wr_domain_i | input | 4 | Domain number |
| wr_tex_i | input | 3 | Type extension attribute |
| wr_c_i | input | 1 | Cacheable attribute |
| wr_b_i | input | 1 | Bufferable attribute |
| wr_s_i | input | 1 | Shareable attribute |
| lookup_i | input | 1 | Lookup strobe |
| va_i | input | 32 | Virtual address |
| asid_i | input | 8 | Current identifier |
| priv_i | input | 1 | 1 = supervisor, 0 = user |
| acc_i | input | 2 | Access type code |
| ns_i | input | 1 | Current state is non-secure |
| res_valid_o | output | 1 | Result valid pulse |
| hit_o | output | 1 | Lookup hit |
| miss_o | output | 1 | Lookup miss |
| pa_o | output | 32 | Physical address |
| ns_o | output | 1 | Memory security attribute |
| domain_o | output | 4 | Domain number |
| tex_o | output | 3 | Type extension attribute |
| c_o | output | 1 | Cacheable attribute |
| b_o | output | 1 | Bufferable attribute |
| s_o | output | 1 | Shareable attribute |
| perm_fault_o | output | 1 | Permission fault |
| dom_fault_o | output | 1 | Domain-fault indication |

## Verification
An entry write and a lookup of that same entry can fall in the same cycle. The bench provokes this by raising `wr_en_i` and `lookup_i` on one edge for entry 7. The write replaces a no-access permission with full access. The bench expects the old denial in that result and the new grant in the next lookup. Overlapping entries are also hit at the same time, and the bench judges them by checking that the lower entry's stricter permission decides the fault.

// File: rtl/lktlb_pkg.sv
package lktlb_pkg;
  localparam int VA_W     = 32;
  localparam int PG_SHIFT = 12;
  localparam int PN_W     = VA_W - PG_SHIFT;
  localparam int ASID_W   = 8;
  localparam int DOM_W    = 4;
  localparam int TEX_W    = 3;

  typedef enum logic [1:0] {
    SZ_16M = 2'b00,
    SZ_4K  = 2'b01,
    SZ_64K = 2'b10,
    SZ_1M  = 2'b11
  } reg_size_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_IF  = 2'b10,
    ACC_RSV = 2'b11
  } acc_e;

  typedef struct packed {
    logic              valid;
    logic [PN_W-1:0]   vpn;
    logic              glob;
    logic [ASID_W-1:0] asid;
    logic [PN_W-1:0]   ppn;
    logic              nsa;
    logic              nstid;
    reg_size_e         size;
    logic              apx;
    logic [1:0]        ap;
    logic              xn;
    logic [DOM_W-1:0]  domain;
    logic [TEX_W-1:0]  tex;
    logic              c;
    logic              b;
    logic              s;
  } lk_entry_t;

  // page-number bits that take part in the compare for a region size
  function automatic logic [PN_W-1:0] keep_mask(reg_size_e sz);
    logic [PN_W-1:0] ones;
    ones = '1;
    unique case (sz)
      SZ_4K:   return ones;
      SZ_64K:  return ones << 4;
      SZ_1M:   return ones << 8;
      default: return ones << 12;
    endcase
  endfunction

  function automatic logic ent_match(lk_entry_t e, logic [PN_W-1:0] vpn,
                                     logic [ASID_W-1:0] asid, logic ns);
    logic [PN_W-1:0] m;
    m = keep_mask(e.size);
    return e.valid && (((vpn ^ e.vpn) & m) == '0) &&
           (e.glob || (e.asid == asid)) && (e.nstid == ns);
  endfunction
endpackage

// File: rtl/lktlb_store.sv
module lktlb_store
  import lktlb_pkg::*;
#(
  parameter  int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  lk_entry_t              wr_ent_i,
  output lk_entry_t [N_ENT-1:0]  ents_o
);
  lk_entry_t [N_ENT-1:0] ents_q;
  lk_entry_t             wr_fixed;

  always_comb begin
    wr_fixed     = wr_ent_i;
    // a non-secure entry may only reach non-secure memory
    wr_fixed.nsa = wr_ent_i.nsa | wr_ent_i.nstid;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ents_q <= '0;
    else if (wr_en_i && (int'(wr_idx_i) < N_ENT)) ents_q[wr_idx_i] <= wr_fixed;
  end

  assign ents_o = ents_q;

  a_r5_nsa_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_ent_i.nstid) |=> ents_q[$past(wr_idx_i)].nsa);
endmodule

// File: rtl/lktlb_match.sv
module lktlb_match
  import lktlb_pkg::*;
#(
  parameter  int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  lk_entry_t [N_ENT-1:0] ents_i,
  input  logic [PN_W-1:0]       vpn_i,
  input  logic [ASID_W-1:0]     asid_i,
  input  logic                  ns_i,
  output logic [N_ENT-1:0]      match_o,
  output logic [N_ENT-1:0]      grant_o,
  output logic [IDX_W-1:0]      sel_idx_o,
  output logic                  any_o
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign match_o[g] = ent_match(ents_i[g], vpn_i, asid_i, ns_i);
  end

  // lowest index wins
  always_comb begin
    sel_idx_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match_o[i]) sel_idx_o = IDX_W'(i);
    end
    any_o   = |match_o;
    grant_o = any_o ? (N_ENT'(1) << sel_idx_o) : '0;
  end
endmodule

// File: rtl/lktlb_perm.sv
module lktlb_perm
  import lktlb_pkg::*;
(
  input  logic       apx_i,
  input  logic [1:0] ap_i,
  input  logic       xn_i,
  input  logic       priv_i,
  input  acc_e       acc_i,
  output logic       perm_fault_o,
  output logic       dom_fault_o
);
  logic rd_ok, wr_ok, need_ok;

  always_comb begin
    unique case ({apx_i, ap_i})
      3'b000:  begin rd_ok = 1'b0;   wr_ok = 1'b0;   end
      3'b001:  begin rd_ok = priv_i; wr_ok = priv_i; end
      3'b010:  begin rd_ok = 1'b1;   wr_ok = priv_i; end
      3'b011:  begin rd_ok = 1'b1;   wr_ok = 1'b1;   end
      3'b101:  begin rd_ok = priv_i; wr_ok = 1'b0;   end
      3'b110,
      3'b111:  begin rd_ok = 1'b1;   wr_ok = 1'b0;   end
      default: begin rd_ok = 1'b0;   wr_ok = 1'b0;   end
    endcase
    need_ok      = (acc_i == ACC_WR) ? wr_ok : rd_ok;
    dom_fault_o  = apx_i && (ap_i == 2'b00);
    perm_fault_o = !dom_fault_o && (!need_ok || ((acc_i == ACC_IF) && xn_i));
  end
endmodule

// File: rtl/lktlb_lookup.sv
module lktlb_lookup
  import lktlb_pkg::*;
#(
  parameter  int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic                  wr_valid_i,
  input  logic [PN_W-1:0]       wr_vpn_i,
  input  logic                  wr_global_i,
  input  logic [ASID_W-1:0]     wr_asid_i,
  input  logic [PN_W-1:0]       wr_ppn_i,
  input  logic                  wr_nsa_i,
  input  logic                  wr_nstid_i,
  input  logic [1:0]            wr_size_i,
  input  logic                  wr_apx_i,
  input  logic [1:0]            wr_ap_i,
  input  logic                  wr_xn_i,
  input  logic [DOM_W-1:0]      wr_domain_i,
  input  logic [TEX_W-1:0]      wr_tex_i,
  input  logic                  wr_c_i,
  input  logic                  wr_b_i,
  input  logic                  wr_s_i,
  input  logic                  lookup_i,
  input  logic [VA_W-1:0]       va_i,
  input  logic [ASID_W-1:0]     asid_i,
  input  logic                  priv_i,
  input  logic [1:0]            acc_i,
  input  logic                  ns_i,
  output logic                  res_valid_o,
  output logic                  hit_o,
  output logic                  miss_o,
  output logic [VA_W-1:0]       pa_o,
  output logic                  ns_o,
  output logic [DOM_W-1:0]      domain_o,
  output logic [TEX_W-1:0]      tex_o,
  output logic                  c_o,
  output logic                  b_o,
  output logic                  s_o,
  output logic                  perm_fault_o,
  output logic                  dom_fault_o
);
  lk_entry_t             wr_ent;
  lk_entry_t [N_ENT-1:0] ents;
  lk_entry_t             sel;
  logic [N_ENT-1:0]      match, grant, valid_vec;
  logic [IDX_W-1:0]      sel_idx;
  logic                  any;
  logic                  pf_raw, df_raw;
  logic [PN_W-1:0]       m_sel;
  logic [VA_W-1:0]       pa_nx;

  always_comb begin
    wr_ent        = '0;
    wr_ent.valid  = wr_valid_i;
    wr_ent.vpn    = wr_vpn_i;
    wr_ent.glob   = wr_global_i;
    wr_ent.asid   = wr_asid_i;
    wr_ent.ppn    = wr_ppn_i;
    wr_ent.nsa    = wr_nsa_i;
    wr_ent.nstid  = wr_nstid_i;
    wr_ent.size   = reg_size_e'(wr_size_i);
    wr_ent.apx    = wr_apx_i;
    wr_ent.ap     = wr_ap_i;
    wr_ent.xn     = wr_xn_i;
    wr_ent.domain = wr_domain_i;
    wr_ent.tex    = wr_tex_i;
    wr_ent.c      = wr_c_i;
    wr_ent.b      = wr_b_i;
    wr_ent.s      = wr_s_i;
  end

  lktlb_store #(.N_ENT(N_ENT)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .wr_idx_i(wr_idx_i),
    .wr_ent_i(wr_ent),
    .ents_o  (ents)
  );

  lktlb_match #(.N_ENT(N_ENT)) u_match (
    .ents_i   (ents),
    .vpn_i    (va_i[VA_W-1:PG_SHIFT]),
    .asid_i   (asid_i),
    .ns_i     (ns_i),
    .match_o  (match),
    .grant_o  (grant),
    .sel_idx_o(sel_idx),
    .any_o    (any)
  );

  assign sel = ents[sel_idx];

  lktlb_perm u_perm (
    .apx_i       (sel.apx),
    .ap_i        (sel.ap),
    .xn_i        (sel.xn),
    .priv_i      (priv_i),
    .acc_i       (acc_e'(acc_i)),
    .perm_fault_o(pf_raw),
    .dom_fault_o (df_raw)
  );

  always_comb begin
    m_sel = keep_mask(sel.size);
    pa_nx = {(sel.ppn & m_sel) | (va_i[VA_W-1:PG_SHIFT] & ~m_sel),
             va_i[PG_SHIFT-1:0]};
    for (int i = 0; i < N_ENT; i++) valid_vec[i] = ents[i].valid;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      hit_o        <= 1'b0;
      miss_o       <= 1'b0;
      pa_o         <= '0;
      ns_o         <= 1'b0;
      domain_o     <= '0;
      tex_o        <= '0;
      c_o          <= 1'b0;
      b_o          <= 1'b0;
      s_o          <= 1'b0;
      perm_fault_o <= 1'b0;
      dom_fault_o  <= 1'b0;
    end else begin
      res_valid_o <= lookup_i;
      if (lookup_i) begin
        hit_o        <= any;
        miss_o       <= !any;
        pa_o         <= any ? pa_nx : '0;
        ns_o         <= any && sel.nsa;
        domain_o     <= any ? sel.domain : '0;
        tex_o        <= any ? sel.tex : '0;
        c_o          <= any && sel.c;
        b_o          <= any && sel.b;
        s_o          <= any && sel.s;
        perm_fault_o <= any && pf_raw;
        dom_fault_o  <= any && df_raw;
      end
    end
  end

  a_r11_strobe_to_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_i |=> res_valid_o);
  a_r11_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_i |=> (!res_valid_o && $stable(pa_o) && $stable(hit_o) && $stable(perm_fault_o)));
  a_r10_miss_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && miss_o) |-> (!perm_fault_o && !dom_fault_o && pa_o == '0));
  a_r10_hit_xor_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (hit_o != miss_o));
  a_r7_fault_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(perm_fault_o && dom_fault_o));
  a_r9_grant_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  a_r9_grant_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((grant - N_ENT'(1)) & match) == '0) && ((grant & ~match) == '0));
  a_r2_grant_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant & ~valid_vec) == '0);
endmodule

// File: tb/lktlb_lookup_bench.sv
`timescale 1ns/1ps
module lktlb_lookup_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        wr_en = 0, wr_valid = 0, wr_global = 0, wr_nsa = 0, wr_nstid = 0;
  logic [2:0]  wr_idx = 0;
  logic [19:0] wr_vpn = 0, wr_ppn = 0;
  logic [7:0]  wr_asid = 0;
  logic [1:0]  wr_size = 0, wr_ap = 0;
  logic        wr_apx = 0, wr_xn = 0, wr_c = 0, wr_b = 0, wr_s = 0;
  logic [3:0]  wr_domain = 0;
  logic [2:0]  wr_tex = 0;
  logic        lookup = 0, priv = 0, ns = 0;
  logic [31:0] va = 0;
  logic [7:0]  asid = 0;
  logic [1:0]  acc = 0;
  logic        res_valid, hit, miss, ns_o, c_o, b_o, s_o, pf, df;
  logic [31:0] pa;
  logic [3:0]  domain_o;
  logic [2:0]  tex_o;

  int n_chk = 0;
  int n_fail = 0;

  lktlb_lookup u_lktlb_lookup (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_valid_i(wr_valid), .wr_vpn_i(wr_vpn),
    .wr_global_i(wr_global), .wr_asid_i(wr_asid), .wr_ppn_i(wr_ppn), .wr_nsa_i(wr_nsa),
    .wr_nstid_i(wr_nstid), .wr_size_i(wr_size), .wr_apx_i(wr_apx), .wr_ap_i(wr_ap),
    .wr_xn_i(wr_xn), .wr_domain_i(wr_domain), .wr_tex_i(wr_tex), .wr_c_i(wr_c),
    .wr_b_i(wr_b), .wr_s_i(wr_s),
    .lookup_i(lookup), .va_i(va), .asid_i(asid), .priv_i(priv), .acc_i(acc), .ns_i(ns),
    .res_valid_o(res_valid), .hit_o(hit), .miss_o(miss), .pa_o(pa), .ns_o(ns_o),
    .domain_o(domain_o), .tex_o(tex_o), .c_o(c_o), .b_o(b_o), .s_o(s_o),
    .perm_fault_o(pf), .dom_fault_o(df)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [7:0]  asid;
    logic        priv;
    logic [1:0]  acc;
    logic        ns;
    logic        hit;
    logic [31:0] pa;
    logic        pf;
    logic        df;
    logic        nso;
  } vec_t;

  localparam int NV = 21;
  // va, asid, priv, acc, ns | hit, pa, perm, dom, ns_o
  localparam vec_t VECS [NV] = '{
    '{32'h0001_0ABC, 8'd0, 1'b1, 2'd0, 1'b0, 1'b1, 32'h8000_0ABC, 1'b0, 1'b0, 1'b0},
    '{32'h0001_0ABC, 8'd0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h8000_0ABC, 1'b1, 1'b0, 1'b0},
    '{32'h0001_0ABC, 8'd0, 1'b0, 2'd1, 1'b0, 1'b1, 32'h8000_0ABC, 1'b1, 1'b0, 1'b0},
    '{32'h0002_F123, 8'd5, 1'b0, 2'd0, 1'b0, 1'b1, 32'h9012_F123, 1'b0, 1'b0, 1'b0},
    '{32'h0002_F123, 8'd5, 1'b0, 2'd1, 1'b0, 1'b1, 32'h9012_F123, 1'b1, 1'b0, 1'b0},
    '{32'h0002_F123, 8'd5, 1'b1, 2'd1, 1'b0, 1'b1, 32'h9012_F123, 1'b0, 1'b0, 1'b0},
    '{32'h0002_F123, 8'd5, 1'b1, 2'd2, 1'b0, 1'b1, 32'h9012_F123, 1'b1, 1'b0, 1'b0},
    '{32'h0002_F123, 8'd6, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0},
    '{32'h010A_BCDE, 8'd0, 1'b1, 2'd0, 1'b1, 1'b1, 32'hA03A_BCDE, 1'b0, 1'b0, 1'b1},
    '{32'h010A_BCDE, 8'd0, 1'b1, 2'd1, 1'b1, 1'b1, 32'hA03A_BCDE, 1'b1, 1'b0, 1'b1},
    '{32'h010A_BCDE, 8'd0, 1'b0, 2'd0, 1'b1, 1'b1, 32'hA03A_BCDE, 1'b1, 1'b0, 1'b1},
    '{32'h010A_BCDE, 8'd0, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0},
    '{32'h04AB_CDEF, 8'd0, 1'b1, 2'd0, 1'b0, 1'b1, 32'hC5AB_CDEF, 1'b0, 1'b1, 1'b1},
    '{32'h04AB_CDEF, 8'd0, 1'b0, 2'd2, 1'b0, 1'b1, 32'hC5AB_CDEF, 1'b0, 1'b1, 1'b1},
    '{32'h0005_0010, 8'd0, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0},
    '{32'h0006_0004, 8'd0, 1'b0, 2'd0, 1'b0, 1'b1, 32'hE000_0004, 1'b0, 1'b0, 1'b0},
    '{32'h0006_0004, 8'd0, 1'b0, 2'd1, 1'b0, 1'b1, 32'hE000_0004, 1'b1, 1'b0, 1'b0},
    '{32'h0006_0004, 8'd0, 1'b1, 2'd1, 1'b0, 1'b1, 32'hE000_0004, 1'b1, 1'b0, 1'b0},
    '{32'h0007_0FFF, 8'd0, 1'b1, 2'd0, 1'b0, 1'b1, 32'hF000_0FFF, 1'b1, 1'b0, 1'b0},
    '{32'h0001_1000, 8'd0, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0},
    '{32'h0001_0ABC, 8'd0, 1'b1, 2'd2, 1'b0, 1'b1, 32'h8000_0ABC, 1'b0, 1'b0, 1'b0}
  };

  function automatic string vtag(int i);
    case (i)
      0, 1, 4, 5, 18: return "R6";
      2:              return "R9";
      3, 7:           return "R3";
      6, 20:          return "R8";
      8:              return "R5";
      11:             return "R4";
      14:             return "R2";
      19:             return "R1";
      default:        return "R7";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_wr(input int idx, input logic v, input logic [19:0] vpn,
                        input logic g, input logic [7:0] id, input logic [19:0] ppn,
                        input logic nsa, input logic nstid, input logic [1:0] sz,
                        input logic apx, input logic [1:0] ap, input logic xn,
                        input logic [3:0] dom, input logic [2:0] tex,
                        input logic c, input logic b, input logic s);
    wr_idx = 3'(idx); wr_valid = v; wr_vpn = vpn; wr_global = g; wr_asid = id;
    wr_ppn = ppn; wr_nsa = nsa; wr_nstid = nstid; wr_size = sz; wr_apx = apx;
    wr_ap = ap; wr_xn = xn; wr_domain = dom; wr_tex = tex; wr_c = c; wr_b = b; wr_s = s;
  endtask

  task automatic commit_wr();
    @(negedge clk); wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_lk(input logic [31:0] a, input logic [7:0] id, input logic p,
                        input logic [1:0] t, input logic n);
    va = a; asid = id; priv = p; acc = t; ns = n;
  endtask

  task automatic do_lookup(input logic [31:0] a, input logic [7:0] id, input logic p,
                           input logic [1:0] t, input logic n);
    @(negedge clk); set_lk(a, id, p, t, n); lookup = 1'b1;
    @(negedge clk); lookup = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL R11 watchdog: actual %h expected %h", 1'b0, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13", "reset outputs", {res_valid, hit, miss, pf, df, pa},
        {5'b0, 32'h0});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13", "after reset release", {res_valid, hit, miss, pf, df, pa},
        {5'b0, 32'h0});

    // idx, v, vpn, g, asid, ppn, nsa, nstid, size, apx, ap, xn, dom, tex, c, b, s
    set_wr(0, 1, 20'h00010, 1, 8'd0, 20'h80000, 0, 0, 2'b01, 0, 2'b01, 0, 4'h0, 3'd0, 0, 0, 0); commit_wr();
    set_wr(1, 1, 20'h00020, 0, 8'd5, 20'h9012A, 0, 0, 2'b10, 0, 2'b10, 1, 4'h0, 3'd0, 0, 0, 0); commit_wr();
    set_wr(2, 1, 20'h01000, 1, 8'd0, 20'hA03FF, 0, 1, 2'b11, 1, 2'b01, 0, 4'h0, 3'd0, 0, 0, 0); commit_wr();
    set_wr(3, 1, 20'h04567, 1, 8'd0, 20'hC5123, 1, 0, 2'b00, 1, 2'b00, 1, 4'hA, 3'd5, 1, 0, 1); commit_wr();
    set_wr(4, 1, 20'h00010, 1, 8'd0, 20'hB0000, 0, 0, 2'b01, 0, 2'b11, 0, 4'h3, 3'd0, 0, 0, 0); commit_wr();
    set_wr(5, 0, 20'h00050, 1, 8'd0, 20'hD0000, 0, 0, 2'b01, 0, 2'b11, 0, 4'h0, 3'd0, 0, 0, 0); commit_wr();
    set_wr(6, 1, 20'h00060, 1, 8'd0, 20'hE0000, 0, 0, 2'b01, 1, 2'b10, 0, 4'h0, 3'd0, 0, 0, 0); commit_wr();
    set_wr(7, 1, 20'h00070, 1, 8'd0, 20'hF0000, 0, 0, 2'b01, 0, 2'b00, 0, 4'h0, 3'd0, 0, 0, 0); commit_wr();

    for (int i = 0; i < NV; i++) begin
      do_lookup(VECS[i].va, VECS[i].asid, VECS[i].priv, VECS[i].acc, VECS[i].ns);
      chk(vtag(i), $sformatf("vector %0d {valid,hit,miss,pa,pf,df,ns}", i),
          {res_valid, hit, miss, pa, pf, df, ns_o},
          {1'b1, VECS[i].hit, ~VECS[i].hit, VECS[i].pa, VECS[i].pf, VECS[i].df, VECS[i].nso});
    end

    // R5 attribute pass-through on entry 3
    do_lookup(32'h04AB_CDEF, 8'd0, 1'b1, 2'd0, 1'b0);
    chk("R5", "attributes {dom,tex,c,b,s,ns}", {domain_o, tex_o, c_o, b_o, s_o, ns_o},
        {4'hA, 3'd5, 1'b1, 1'b0, 1'b1, 1'b1});
    // R10 miss right after a hit clears everything
    do_lookup(32'h0900_0000, 8'd0, 1'b1, 2'd0, 1'b0);
    chk("R10", "miss {hit,miss,pf,df,pa,dom,tex,c,b,s,ns}",
        {hit, miss, pf, df, pa, domain_o, tex_o, c_o, b_o, s_o, ns_o},
        {1'b0, 1'b1, 2'b00, 32'h0, 4'h0, 3'd0, 4'b0});
    // R11 valid pulse and hold while idle
    do_lookup(32'h0001_0ABC, 8'd0, 1'b1, 2'd0, 1'b0);
    chk("R11", "result valid after strobe", {res_valid, pa}, {1'b1, 32'h8000_0ABC});
    @(negedge clk);
    chk("R11", "idle drops valid, holds pa", {res_valid, hit, miss, pa},
        {1'b0, 1'b1, 1'b0, 32'h8000_0ABC});

    // R12 write entry 7 to full access in the lookup cycle
    @(negedge clk);
    set_wr(7, 1, 20'h00070, 1, 8'd0, 20'hF0000, 0, 0, 2'b01, 0, 2'b11, 0, 4'h0, 3'd0, 0, 0, 0);
    set_lk(32'h0007_0010, 8'd0, 1'b1, 2'd0, 1'b0);
    wr_en = 1'b1; lookup = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; lookup = 1'b0;
    chk("R12", "same-cycle lookup sees old entry {hit,pf,pa}", {hit, pf, pa},
        {1'b1, 1'b1, 32'hF000_0010});
    do_lookup(32'h0007_0010, 8'd0, 1'b1, 2'd0, 1'b0);
    chk("R12", "next lookup sees new entry {hit,pf,pa}", {hit, pf, pa},
        {1'b1, 1'b0, 32'hF000_0010});

    // R2 validating entry 5 makes it match
    set_wr(5, 1, 20'h00050, 1, 8'd0, 20'hD0000, 0, 0, 2'b01, 0, 2'b11, 0, 4'h0, 3'd0, 0, 0, 0); commit_wr();
    do_lookup(32'h0005_0010, 8'd0, 1'b0, 2'd1, 1'b0);
    chk("R2", "revalidated entry {hit,pf,pa}", {hit, pf, pa}, {1'b1, 1'b0, 32'hD000_0010});

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule